// File: doc/BRIEF.md
# ADC Output Word Serializer

This block models the digital output stage of a sampling converter as seen from the host side of a three-wire serial link. A parallel input and a load strobe stand in for the analog front end. A fixed countdown of system clocks stands in for the conversion time. When the countdown ends, the block clamps the latest loaded value to one code beyond each full-scale limit. It then formats the value into a status-plus-data word and holds it until the host reads it.

The host lowers an active-low chip select and clocks the word out, most significant bit first. The block changes the data line after each falling edge of the serial clock, so the host samples on rising edges. The same data line also shows converter status. While chip select is low it reads high during a conversion and low once a result is waiting. After the last bit of a complete read, a new conversion starts on its own. If chip select rises before the word is complete, the read is cancelled and the result is kept for a later read. The serial clock and chip select are synchronized into the system clock domain. The output enable follows chip select directly.

Top module: `adc_word_serializer`

## Requirements
- R1: Reset places the block in conversion. The first result becomes ready on exactly the CONV_CYCLES-th rising clock edge after reset is released. Until then `sdo` reads 1 while `csN` is low.
- R2: The word, for a clamped value v, is laid out as follows. Bit WORD_W-1 is the ready flag (0). Bit WORD_W-2 is 0. Bits WORD_W-3 down to 0 hold v as a (WORD_W-2)-bit two's complement number with its top bit inverted. In-range values lie from -FS to FS-1, where FS = 2^(WORD_W-4).
- R3: A value above FS is sent as the code for FS: the inverted sign bit 1, the next bit 1 and all lower bits 0.
- R4: A value below -FS-1 is sent as the code for -FS-1: the inverted sign bit 0, the next bit 0 and all lower bits 1.
- R5: `sdoOe` is 0 whenever `csN` is 1 and 1 whenever `csN` is 0.
- R6: With `csN` low, `sdo` is 1 during conversion. It is 0 (the ready flag) as soon as a result is held and no bit has yet been shifted.
- R7: Bits leave MSB first. Each bit changes only after a falling edge of `sck` and stays stable across the following rising edge.
- R8: After the WORD_W-th falling `sck` edge of an unbroken read, a new conversion starts and `sdo` reads 1.
- R9: Raising `csN` before the word is complete returns the block to sleep with the result held. The next read starts again from bit WORD_W-1 and sends the same word.
- R10: The conversion result is the value from the most recent `sampleLoad` pulse. A pulse on the very edge where conversion ends is the one taken. Pulses after that edge do not change the held word, but they feed the next conversion.
- R11: Sleep lasts for as long as no complete read occurs. With `csN` high, no new conversion starts and the held word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleLoad | input | 1 | Strobe that captures `sampleIn` as the next conversion value |
| sampleIn | input | IN_W | Signed conversion value in LSB units |
| sck | input | 1 | Host serial clock, asynchronous to `clk` |
| csN | input | 1 | Active-low chip select, asynchronous to `clk` |
| sdo | output | 1 | Serial data and busy/ready indication |
| sdoOe | output | 1 | Output enable for `sdo`; the line is high-impedance when 0 |

## Verification
Two events can fall on the same clock edge: a `sampleLoad` pulse and the end of the conversion countdown. The bench counts edges from reset release and places one pulse exactly on the capture edge, with an older pulse two edges earlier. The word that is read must carry the newer value. A third pulse one edge after capture must not show up in that word, but must show up in the word after it. The bench also lets chip select rise in the middle of a word. It checks that the next read starts again from the ready flag with an identical word.

// File: rtl/aws_pkg.sv
package aws_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } awsState_t;

  typedef struct packed {
    logic capture;
    logic reload;
    logic shift;
  } awsStrb_t;

endpackage

// File: rtl/aws_ctrl.sv
module aws_ctrl
  import aws_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int CONV_CYCLES = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sckIn,
  input  logic     csNIn,
  output awsStrb_t strb,
  output logic     busy
);

  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  logic sckS1, sckS2, sckS3;
  logic csS1, csS2;
  logic sckFall, csLow;

  awsState_t stateQ, stateD;
  logic [CW-1:0] convCnt, convCntD;
  logic [BW-1:0] bitCnt, bitCntD;

  // two-flop synchronizers plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sckS1 <= 1'b0;
      sckS2 <= 1'b0;
      sckS3 <= 1'b0;
      csS1  <= 1'b1;
      csS2  <= 1'b1;
    end else begin
      sckS1 <= sckIn;
      sckS2 <= sckS1;
      sckS3 <= sckS2;
      csS1  <= csNIn;
      csS2  <= csS1;
    end
  end

  assign sckFall = sckS3 & ~sckS2;
  assign csLow   = ~csS2;

  always_comb begin
    stateD   = stateQ;
    convCntD = convCnt;
    bitCntD  = bitCnt;
    strb     = '0;
    unique case (stateQ)
      ST_CONV: begin
        if (convCnt == '0) begin
          stateD       = ST_SLEEP;
          strb.capture = 1'b1;
        end else begin
          convCntD = convCnt - 1'b1;
        end
      end
      ST_SLEEP: begin
        if (csLow) begin
          stateD  = ST_OUT;
          bitCntD = '0;
        end
      end
      ST_OUT: begin
        if (!csLow) begin
          stateD      = ST_SLEEP;
          strb.reload = 1'b1;
        end else if (sckFall) begin
          if (bitCnt == LAST_BIT) begin
            stateD   = ST_CONV;
            convCntD = CW'(CONV_CYCLES - 1);
          end else begin
            strb.shift = 1'b1;
            bitCntD    = bitCnt + 1'b1;
          end
        end
      end
      default: stateD = ST_CONV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ  <= ST_CONV;
      convCnt <= CW'(CONV_CYCLES - 1);
      bitCnt  <= '0;
    end else begin
      stateQ  <= stateD;
      convCnt <= convCntD;
      bitCnt  <= bitCntD;
    end
  end

  assign busy = (stateQ == ST_CONV);

  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_CONV && convCnt != '0) |=> (stateQ == ST_CONV)); // R1
  AST_LAST_BIT_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_OUT && csLow && sckFall && bitCnt == LAST_BIT) |=> (stateQ == ST_CONV)); // R8
  AST_ABORT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_OUT && !csLow) |=> (stateQ == ST_SLEEP)); // R9
  AST_SLEEP_NO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_SLEEP) |=> (stateQ != ST_CONV)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.capture, strb.reload, strb.shift})); // R7

endmodule

// File: rtl/aws_datapath.sv
module aws_datapath
  import aws_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IN_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  awsStrb_t               strb,
  input  logic                   sampleLoad,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic                   topBit
);

  localparam int FIELD_W = WORD_W - 3;
  localparam logic [WORD_W-1:0] ZERO_CODE = WORD_W'(1) << FIELD_W;

  logic signed [IN_W-1:0] sampleQ;
  logic signed [IN_W-1:0] selV;
  logic signed [FIELD_W:0] clampV;
  logic [WORD_W-1:0] fmtWord;
  logic [WORD_W-1:0] resultQ;
  logic [WORD_W-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rst_n) sampleQ <= '0;
    else if (sampleLoad) sampleQ <= sampleIn;
  end

  // a strobe coinciding with the capture edge takes precedence
  assign selV = sampleLoad ? sampleIn : sampleQ;

  generate
    if (IN_W > FIELD_W) begin : g_clamp
      localparam logic signed [IN_W-1:0] HI_LIM = IN_W'(1) << (FIELD_W - 1);
      localparam logic signed [IN_W-1:0] LO_LIM = -HI_LIM - 1;
      always_comb begin
        if (selV > HI_LIM)      clampV = HI_LIM[FIELD_W:0];
        else if (selV < LO_LIM) clampV = LO_LIM[FIELD_W:0];
        else                    clampV = selV[FIELD_W:0];
      end
    end else begin : g_extend
      assign clampV = {{(FIELD_W + 1 - IN_W){selV[IN_W-1]}}, selV};
    end
  endgenerate

  assign fmtWord = {2'b00, ~clampV[FIELD_W], clampV[FIELD_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultQ <= ZERO_CODE;
      shiftQ  <= ZERO_CODE;
    end else begin
      if (strb.capture) begin
        resultQ <= fmtWord;
        shiftQ  <= fmtWord;
      end else if (strb.reload) begin
        shiftQ <= resultQ;
      end else if (strb.shift) begin
        shiftQ <= {shiftQ[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign topBit = shiftQ[WORD_W-1];

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(resultQ)); // R10
  AST_LEAD_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> (shiftQ[WORD_W-1:WORD_W-2] == 2'b00)); // R6
  AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (resultQ[FIELD_W] && resultQ[FIELD_W-1]) |-> (resultQ[FIELD_W-2:0] == '0)); // R3
  AST_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!resultQ[FIELD_W] && !resultQ[FIELD_W-1]) |-> (&resultQ[FIELD_W-2:0])); // R4
  AST_RELOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reload |=> (shiftQ == resultQ)); // R9

endmodule

// File: rtl/adc_word_serializer.sv
module adc_word_serializer
  import aws_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int IN_W        = 32,
  parameter int CONV_CYCLES = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sampleLoad,
  input  logic signed [IN_W-1:0] sampleIn,
  input  logic                   sck,
  input  logic                   csN,
  output logic                   sdo,
  output logic                   sdoOe
);

  awsStrb_t strb;
  logic busy;
  logic topBit;

  aws_ctrl #(
    .WORD_W      (WORD_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sckIn (sck),
    .csNIn (csN),
    .strb  (strb),
    .busy  (busy)
  );

  aws_datapath #(
    .WORD_W (WORD_W),
    .IN_W   (IN_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .sampleLoad (sampleLoad),
    .sampleIn   (sampleIn),
    .topBit     (topBit)
  );

  assign sdo   = busy ? 1'b1 : topBit;
  assign sdoOe = ~csN;

endmodule

// File: tb/adc_word_serializer_tb_top.sv
module adc_word_serializer_tb_top;

  localparam int WW   = 8;
  localparam int IW   = 8;
  localparam int CC   = 12;
  localparam int FW   = WW - 3;
  localparam int FS   = 1 << (FW - 1);
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleLoad = 1'b0;
  logic signed [IW-1:0] sampleIn = '0;
  logic sck = 1'b0;
  logic csN = 1'b0;
  logic sdo, sdoOe;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_word_serializer #(
    .WORD_W      (WW),
    .IN_W        (IW),
    .CONV_CYCLES (CC)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleLoad (sampleLoad),
    .sampleIn   (sampleIn),
    .sck        (sck),
    .csN        (csN),
    .sdo        (sdo),
    .sdoOe      (sdoOe)
  );

  function automatic logic [WW-1:0] expWord(int v);
    int c;
    logic [FW:0] f;
    c = v;
    if (c > FS) c = FS;
    if (c < -FS - 1) c = -FS - 1;
    f = (FW + 1)'(c);
    f[FW] = ~f[FW];
    return {2'b00, f};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clocks nbits out; returns the bits seen and whether each held across its rising edge
  task automatic readWord(input int nbits, output logic [WW-1:0] w, output bit stableOk);
    logic b;
    w = '0;
    stableOk = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      b = sdo;
      w = {w[WW-2:0], b};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdo !== b) stableOk = 1'b0;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic pulseLoad(int v);
    @(negedge clk);
    sampleIn = IW'(v);
    sampleLoad = 1'b1;
    @(negedge clk);
    sampleLoad = 1'b0;
  endtask

  task automatic waitReady();
    while (sdo !== 1'b0) @(negedge clk);
  endtask

  initial begin
    logic [WW-1:0] w;
    bit st;
    // reset state
    repeat (3) @(negedge clk);
    chk("R1 sdo busy in reset", 32'(sdo), 32'd1);
    chk("R5 oe with csN low", 32'(sdoOe), 32'd1);
    rst_n = 1'b1;
    // same-edge load versus conversion end
    repeat (CC - 3) @(negedge clk);
    sampleIn = IW'(-3); sampleLoad = 1'b1;
    @(negedge clk);
    sampleLoad = 1'b0;
    @(negedge clk);
    chk("R1 busy before last edge", 32'(sdo), 32'd1);
    sampleIn = IW'(7); sampleLoad = 1'b1;
    @(negedge clk);
    sampleLoad = 1'b0;
    chk("R1 ready on CONV_CYCLES edge", 32'(sdo), 32'd0);
    sampleIn = IW'(-9); sampleLoad = 1'b1;
    @(negedge clk);
    sampleLoad = 1'b0;
    readWord(WW, w, st);
    chk("R10 same-edge strobe wins", 32'(w), 32'(expWord(7)));
    chk("R7 bits stable over rising edge", 32'(st), 32'd1);
    chk("R8 busy after final bit", 32'(sdo), 32'd1);
    waitReady();
    readWord(WW, w, st);
    chk("R10 late strobe feeds next word", 32'(w), 32'(expWord(-9)));
    // sweep every input code
    for (int v = -(1 << (IW - 1)); v < (1 << (IW - 1)); v++) begin
      pulseLoad(v);
      waitReady();
      readWord(WW, w, st);
      if (v > FS)           chk("R3 clamp above", 32'(w), 32'(expWord(v)));
      else if (v < -FS - 1) chk("R4 clamp below", 32'(w), 32'(expWord(v)));
      else                  chk("R2 in-range code", 32'(w), 32'(expWord(v)));
      chk("R7 stable", 32'(st), 32'd1);
      chk("R8 busy after read", 32'(sdo), 32'd1);
    end
    // sleep with chip select high
    pulseLoad(11);
    csN = 1'b1;
    @(negedge clk);
    chk("R5 hi-Z with csN high", 32'(sdoOe), 32'd0);
    repeat (80) @(negedge clk);
    chk("R5 hi-Z in sleep", 32'(sdoOe), 32'd0);
    csN = 1'b0;
    @(negedge clk);
    chk("R6 ready flag on select", 32'(sdo), 32'd0);
    readWord(WW, w, st);
    chk("R11 word kept through sleep", 32'(w), 32'(expWord(11)));
    // abort mid-word
    pulseLoad(-20);
    waitReady();
    readWord(3, w, st);
    csN = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 hi-Z after abort", 32'(sdoOe), 32'd0);
    csN = 1'b0;
    @(negedge clk);
    chk("R9 abort back to ready flag", 32'(sdo), 32'd0);
    readWord(WW, w, st);
    chk("R9 full word after abort", 32'(w), 32'(expWord(-20)));
    chk("R8 busy after reread", 32'(sdo), 32'd1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule